// File: doc/BRIEF.md
# Strip Sample Reorder Buffer

This block sits behind four front-end digitiser inputs. Each input reports 128 channels per time sample, and each trigger yields six consecutive time samples spaced one 25 ns clock apart. The samples arrive one time block after another. Each write slot carries one sample from every input, together with its channel index, the time-block index and a hit flag. The block stores them so that the downstream hit processor can take each strip with all six of its samples in a row.

The four inputs share a single 512-strip space. The two upper strip-address bits pick the input memory and the seven lower bits pick the channel inside it. Storage is split into two banks. One complete event can drain through the valid/ready output while the next event is being written. When both banks hold complete events that have not yet been read, the block raises busy and drops further input slots.

Top module: `strip_reorder_buf`

## Requirements
- R1: After reset, out_valid and busy are low.
- R2: The sample of input i (0..3) at channel c (0..127) is read out as strip i*128+c. Strip bits 8:7 equal the input number and bits 6:0 equal the channel. The channel of input i arrives on in_chan bits [7i+6:7i].
- R3: Every stored sample is 9 bits: the hit flag from in_hit bit i, above the 8-bit pulse height from in_height bits [8i+7:8i]. A strip's output word with out_tb = t carries the hit flag and height that were written with in_tb = t for that strip, whatever order the channels and time blocks were written in.
- R4: Read-out covers strips 0 to 511 in rising order. Each strip gives six consecutive words with out_tb 0 to 5. out_last is high only on strip 511, time block 5, and the next event restarts at strip 0, time block 0.
- R5: An event is complete after 768 accepted write slots (6 × 128). out_valid rises in the cycle after the edge that accepts the 768th slot when no earlier event is waiting, and stays low after 767 slots.
- R6: A slot with in_sof high starts a new event. It counts as slot one, and any partial count before it is discarded.
- R7: A slot whose in_tb is 6 or 7 is ignored. It writes nothing and does not count toward the 768.
- R8: A second event can be written while the first waits in the other bank. busy goes high when both banks hold complete events, and every slot presented while busy is high is ignored.
- R9: While out_valid is high and out_ready is low, all outputs hold steady. No word is lost or repeated.
- R10: The handshake on the last word frees that bank. A busy that was high drops in the next cycle, and the other bank's event is presented from strip 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Write slot present |
| in_sof | input | 1 | Slot is the first of a new event |
| in_tb | input | 3 | Time-block index of the slot (0..5) |
| in_chan | input | 28 | Channel index per input, 7 bits each |
| in_height | input | 32 | Pulse height per input, 8 bits each |
| in_hit | input | 4 | Hit flag per input |
| busy | output | 1 | Both banks full; input slots are dropped |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_strip | output | 9 | Strip number 0..511 |
| out_tb | output | 3 | Time block 0..5 of the word |
| out_height | output | 8 | Pulse height |
| out_hit | output | 1 | Hit flag |
| out_last | output | 1 | Final word of the event |

## Verification
Events are written in four orders: all inputs in ascending channel order, all in descending order, a different odd-stride permutation on each input, and a mix of reversed and strided inputs. Time blocks are written both rising and falling. An error in the address split or the lane placement therefore shows up as a value mismatch, and an unpermuted pattern could not expose it. The sample values are a function of strip and time block, so any swap of inputs, channels or lanes is caught.

Read-out runs with ready held high, ready every other cycle, ready one cycle in three, and an irregular pattern, which separates correct stalling from lost or repeated words. Directed sequences cover the following:
- slot-count edges around the 768th slot;
- a restart by in_sof after a partial event;
- slots with out-of-range time blocks;
- a slot presented while both banks are full, checked both for data corruption and for a wrong count.

// File: rtl/srb_pkg.sv
package srb_pkg;
    // Default geometry of the reorder buffer
    localparam int unsigned SRB_NUM_IN    = 4;
    localparam int unsigned SRB_CH_PER_IN = 128;
    localparam int unsigned SRB_NUM_TB    = 6;
    localparam int unsigned SRB_HGT_W     = 8;
endpackage

// File: rtl/srb_lane_mem.sv
// One input's channel memory in one bank: each word holds all time blocks
// of a channel, written one lane at a time, read as a whole word.
module srb_lane_mem #(
    parameter int unsigned DEPTH  = 128,
    parameter int unsigned NUM_TB = 6,
    parameter int unsigned SAMP_W = 9,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned TB_W   = $clog2(NUM_TB),
    localparam int unsigned WORD_W = NUM_TB * SAMP_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [TB_W-1:0]   wlane,
    input  logic [SAMP_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rword
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr][int'(wlane)*SAMP_W +: SAMP_W] <= wdata;
        end
    end

    assign rword = mem_q[raddr];
endmodule

// File: rtl/srb_wr_ctrl.sv
// Write-slot qualification and per-event slot counting.
module srb_wr_ctrl #(
    parameter int unsigned NUM_TB    = 6,
    parameter int unsigned CH_PER_IN = 128,
    localparam int unsigned TB_W     = $clog2(NUM_TB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_sof,
    input  logic [TB_W-1:0] in_tb,
    input  logic            bank_free,
    output logic            wr_en,
    output logic            commit
);
    localparam int unsigned SLOTS  = NUM_TB * CH_PER_IN;
    localparam int unsigned SLOT_W = $clog2(SLOTS + 1);
    localparam logic [TB_W-1:0]   TB_MAX    = TB_W'(NUM_TB - 1);
    localparam logic [SLOT_W-1:0] SLOT_FULL = SLOT_W'(SLOTS);

    typedef struct packed {
        logic [SLOT_W-1:0] cnt;
    } wr_state_t;

    wr_state_t         st_d, st_q;
    logic [SLOT_W-1:0] cnt_next;

    always_comb begin
        st_d     = st_q;
        wr_en    = 1'b0;
        commit   = 1'b0;
        cnt_next = st_q.cnt + SLOT_W'(1);
        if (in_valid && bank_free && (in_tb <= TB_MAX)) begin
            wr_en = 1'b1;
            if (in_sof) begin
                cnt_next = SLOT_W'(1);
            end
            if (cnt_next == SLOT_FULL) begin
                commit   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/srb_bank_track.sv
// Ping-pong bank ownership: full flags and write/read bank pointers.
module srb_bank_track (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic rd_done,
    output logic wr_bank,
    output logic rd_bank,
    output logic bank_free,
    output logic rd_avail
);
    typedef struct packed {
        logic [1:0] full;
        logic       wr_bank;
        logic       rd_bank;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.full[st_q.wr_bank] = 1'b1;
            st_d.wr_bank            = ~st_q.wr_bank;
        end
        if (rd_done) begin
            st_d.full[st_q.rd_bank] = 1'b0;
            st_d.rd_bank            = ~st_q.rd_bank;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_bank   = st_q.wr_bank;
    assign rd_bank   = st_q.rd_bank;
    assign bank_free = ~st_q.full[st_q.wr_bank];
    assign rd_avail  = st_q.full[st_q.rd_bank];
endmodule

// File: rtl/srb_rd_ctrl.sv
// Strip-major read sequencer with valid/ready handshake.
module srb_rd_ctrl #(
    parameter int unsigned NUM_TB    = 6,
    parameter int unsigned NUM_STRIP = 512,
    localparam int unsigned TB_W     = $clog2(NUM_TB),
    localparam int unsigned STRIP_W  = $clog2(NUM_STRIP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               avail,
    input  logic               out_ready,
    output logic [STRIP_W-1:0] strip,
    output logic [TB_W-1:0]    tb,
    output logic               valid,
    output logic               last,
    output logic               done
);
    localparam logic [TB_W-1:0]    TB_MAX    = TB_W'(NUM_TB - 1);
    localparam logic [STRIP_W-1:0] STRIP_MAX = STRIP_W'(NUM_STRIP - 1);

    typedef struct packed {
        logic [STRIP_W-1:0] strip;
        logic [TB_W-1:0]    tb;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        valid = avail;
        last  = (st_q.strip == STRIP_MAX) && (st_q.tb == TB_MAX);
        done  = valid && out_ready && last;
        if (valid && out_ready) begin
            if (st_q.tb == TB_MAX) begin
                st_d.tb    = '0;
                st_d.strip = last ? '0 : st_q.strip + STRIP_W'(1);
            end else begin
                st_d.tb = st_q.tb + TB_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strip = st_q.strip;
    assign tb    = st_q.tb;
endmodule

// File: rtl/strip_reorder_buf.sv
module strip_reorder_buf #(
    parameter int unsigned NUM_IN    = srb_pkg::SRB_NUM_IN,
    parameter int unsigned CH_PER_IN = srb_pkg::SRB_CH_PER_IN,
    parameter int unsigned NUM_TB    = srb_pkg::SRB_NUM_TB,
    parameter int unsigned HGT_W     = srb_pkg::SRB_HGT_W,
    localparam int unsigned CH_W      = $clog2(CH_PER_IN),
    localparam int unsigned IN_W      = $clog2(NUM_IN),
    localparam int unsigned STRIP_W   = CH_W + IN_W,
    localparam int unsigned TB_W      = $clog2(NUM_TB),
    localparam int unsigned NUM_STRIP = NUM_IN * CH_PER_IN
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic [TB_W-1:0]         in_tb,
    input  logic [NUM_IN*CH_W-1:0]  in_chan,
    input  logic [NUM_IN*HGT_W-1:0] in_height,
    input  logic [NUM_IN-1:0]       in_hit,
    output logic                    busy,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [STRIP_W-1:0]      out_strip,
    output logic [TB_W-1:0]         out_tb,
    output logic [HGT_W-1:0]        out_height,
    output logic                    out_hit,
    output logic                    out_last
);
    localparam int unsigned SAMP_W   = HGT_W + 1;
    localparam int unsigned WORD_W   = NUM_TB * SAMP_W;
    localparam int unsigned NUM_BANK = 2;

    logic               wr_en, commit, bank_free, rd_avail;
    logic               wr_bank, rd_bank, rd_done;
    logic [STRIP_W-1:0] rd_strip;
    logic [TB_W-1:0]    rd_tb;
    logic [WORD_W-1:0]  rd_word [NUM_BANK][NUM_IN];
    logic [WORD_W-1:0]  sel_word;
    logic [SAMP_W-1:0]  sel_samp;

    srb_wr_ctrl #(.NUM_TB(NUM_TB), .CH_PER_IN(CH_PER_IN)) i_wr_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_tb     (in_tb),
        .bank_free (bank_free),
        .wr_en     (wr_en),
        .commit    (commit)
    );

    srb_bank_track i_bank_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .rd_done   (rd_done),
        .wr_bank   (wr_bank),
        .rd_bank   (rd_bank),
        .bank_free (bank_free),
        .rd_avail  (rd_avail)
    );

    srb_rd_ctrl #(.NUM_TB(NUM_TB), .NUM_STRIP(NUM_STRIP)) i_rd_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .avail     (rd_avail),
        .out_ready (out_ready),
        .strip     (rd_strip),
        .tb        (rd_tb),
        .valid     (out_valid),
        .last      (out_last),
        .done      (rd_done)
    );

    // One memory per (bank, input); the input number is the upper strip field
    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        for (genvar i = 0; i < NUM_IN; i++) begin : g_in
            srb_lane_mem #(
                .DEPTH  (CH_PER_IN),
                .NUM_TB (NUM_TB),
                .SAMP_W (SAMP_W)
            ) i_mem (
                .clk   (clk),
                .we    (wr_en && (wr_bank == 1'(b))),
                .waddr (in_chan[i*CH_W +: CH_W]),
                .wlane (in_tb),
                .wdata ({in_hit[i], in_height[i*HGT_W +: HGT_W]}),
                .raddr (rd_strip[CH_W-1:0]),
                .rword (rd_word[b][i])
            );
        end
    end

    always_comb begin
        sel_word = rd_word[rd_bank][rd_strip[STRIP_W-1:CH_W]];
        sel_samp = sel_word[int'(rd_tb)*SAMP_W +: SAMP_W];
    end

    assign busy       = ~bank_free;
    assign out_strip  = rd_strip;
    assign out_tb     = rd_tb;
    assign out_hit    = sel_samp[SAMP_W-1];
    assign out_height = sel_samp[HGT_W-1:0];
endmodule

// File: rtl/srb_checks.sv
module srb_checks #(
    parameter int unsigned NUM_TB    = 6,
    parameter int unsigned NUM_STRIP = 512,
    parameter int unsigned HGT_W     = 8,
    localparam int unsigned TB_W     = $clog2(NUM_TB),
    localparam int unsigned STRIP_W  = $clog2(NUM_STRIP)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               out_valid,
    input logic               out_ready,
    input logic [STRIP_W-1:0] out_strip,
    input logic [TB_W-1:0]    out_tb,
    input logic [HGT_W-1:0]   out_height,
    input logic               out_hit,
    input logic               out_last
);
    localparam logic [TB_W-1:0] TB_MAX = TB_W'(NUM_TB - 1);

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_strip) && $stable(out_tb)
            && $stable(out_height) && $stable(out_hit) && $stable(out_last));

    a_r4_tb_step: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last && (out_tb != TB_MAX)
            |=> out_valid && (out_strip == $past(out_strip)) && (out_tb == $past(out_tb) + TB_W'(1)));

    a_r4_strip_step: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last && (out_tb == TB_MAX)
            |=> out_valid && (out_tb == '0) && (out_strip == $past(out_strip) + STRIP_W'(1)));

    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid || ((out_strip == '0) && (out_tb == '0)));

    a_r4_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_strip == '0) && (out_tb == '0));

    a_r4_tb_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_tb <= TB_MAX);

    a_r8_busy_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> out_valid);
endmodule

bind strip_reorder_buf srb_checks #(
    .NUM_TB    (NUM_TB),
    .NUM_STRIP (NUM_STRIP),
    .HGT_W     (HGT_W)
) i_srb_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_strip  (out_strip),
    .out_tb     (out_tb),
    .out_height (out_height),
    .out_hit    (out_hit),
    .out_last   (out_last)
);

// File: tb/test_strip_reorder_buf.sv
`timescale 1ns/1ps
module test_strip_reorder_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [2:0]  in_tb = '0;
    logic [27:0] in_chan = '0;
    logic [31:0] in_height = '0;
    logic [3:0]  in_hit = '0;
    logic        busy, out_valid, out_hit, out_last;
    logic        out_ready = 1'b0;
    logic [8:0]  out_strip;
    logic [2:0]  out_tb;
    logic [7:0]  out_height;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    strip_reorder_buf i_strip_reorder_buf (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_tb(in_tb),
        .in_chan(in_chan), .in_height(in_height), .in_hit(in_hit), .busy(busy),
        .out_valid(out_valid), .out_ready(out_ready), .out_strip(out_strip), .out_tb(out_tb),
        .out_height(out_height), .out_hit(out_hit), .out_last(out_last)
    );

    // stimulus/expected vectors: seed, channel order, time-block order, ready pattern, words
    typedef struct packed {
        logic [7:0]  seed;
        logic [1:0]  chmode;
        logic        tbdesc;
        logic [1:0]  stall;
        logic [11:0] words;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{8'd1, 2'd0, 1'b0, 2'd0, 12'd3072},
        '{8'd2, 2'd1, 1'b1, 2'd1, 12'd3072},
        '{8'd3, 2'd2, 1'b0, 2'd2, 12'd3072},
        '{8'd4, 2'd3, 1'b1, 2'd3, 12'd3072}
    };

    function automatic logic [6:0] chan_of(int mode, int k, int i);
        case (mode)
            0:       return 7'(k);
            1:       return 7'(127 - k);
            2:       return 7'((5 * k + 17 * i) % 128);
            default: return (i % 2 == 1) ? 7'(127 - k) : 7'((3 * k + i) % 128);
        endcase
    endfunction

    function automatic logic [8:0] samp_of(int seed, int strip, int tb);
        logic [7:0] h;
        logic       hit;
        h   = 8'((strip * 7 + tb * 31 + seed * 13 + (strip >> 3)) % 256);
        hit = ((strip + tb + seed) % 3) == 0;
        return {hit, h};
    endfunction

    function automatic logic ready_of(int stall, int cyc);
        case (stall)
            0:       return 1'b1;
            1:       return cyc % 2 == 0;
            2:       return cyc % 3 == 0;
            default: return ((cyc * 7) % 5) < 2;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_slot(input logic sof, input int tb, input int seed, input int mode, input int k);
        logic [8:0] s;
        logic [6:0] c;
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = sof;
        in_tb    = 3'(tb);
        for (int i = 0; i < 4; i++) begin
            c = chan_of(mode, k, i);
            s = samp_of(seed, i * 128 + int'(c), tb);
            in_chan[i*7 +: 7]   = c;
            in_hit[i]           = s[8];
            in_height[i*8 +: 8] = s[7:0];
        end
    endtask

    task automatic write_slots(input int seed, input int mode, input bit tbdesc, input bit use_sof,
                               input int first, input int count);
        for (int n = first; n < first + count; n++) begin
            int tbi;
            tbi = n / 128;
            drive_slot(use_sof && (n == 0), tbdesc ? 5 - tbi : tbi, seed, mode, n % 128);
        end
    endtask

    task automatic drive_junk(input logic sof, input logic [2:0] tb);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sof    = sof;
        in_tb     = tb;
        in_chan   = 28'h5A5A5A5;
        in_height = 32'hFFFF_FFFF;
        in_hit    = 4'hF;
    endtask

    task automatic idle_in();
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    task automatic drain(input int seed, input int stall, input int words);
        int n = 0;
        int cyc = 0;
        logic [63:0] act, exp;
        while (n < words && cyc < 40000) begin
            @(negedge clk);
            out_ready = ready_of(stall, cyc);
            cyc++;
            if (out_valid && out_ready) begin
                act = 64'({out_strip, out_tb, out_hit, out_height, out_last});
                exp = 64'({9'(n / 6), 3'(n % 6), samp_of(seed, n / 6, n % 6), n == words - 1});
                chk(act == exp, "R2 R3 R4 word {strip,tb,hit,height,last}", act, exp);
                n++;
            end
        end
        chk(n == words, "R9 words drained", 64'(n), 64'(words));
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic finish_up();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung act=timeout exp=finished");
            finish_up();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0 && busy == 1'b0, "R1 in reset {valid,busy}", 64'({out_valid, busy}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && busy == 1'b0, "R1 after reset {valid,busy}", 64'({out_valid, busy}), 64'(0));

        // Table walk: orderings and ready patterns (R2 R3 R4 R5 R9)
        for (int v = 0; v < 4; v++) begin
            write_slots(VECS[v].seed, VECS[v].chmode, VECS[v].tbdesc, 1'b1, 0, 767);
            idle_in();
            chk(out_valid == 1'b0, "R5 valid after 767 slots", 64'(out_valid), 64'(0));
            write_slots(VECS[v].seed, VECS[v].chmode, VECS[v].tbdesc, 1'b1, 767, 1);
            idle_in();
            chk(out_valid == 1'b1, "R5 valid after 768 slots", 64'(out_valid), 64'(1));
            drain(VECS[v].seed, VECS[v].stall, VECS[v].words);
        end

        // R7: out-of-range time blocks are neither written nor counted
        write_slots(9, 2, 1'b0, 1'b1, 0, 400);
        drive_junk(1'b0, 3'd6);
        drive_junk(1'b0, 3'd7);
        write_slots(9, 2, 1'b0, 1'b1, 400, 367);
        idle_in();
        chk(out_valid == 1'b0, "R7 valid after 767 valid slots plus 2 bad tb", 64'(out_valid), 64'(0));
        write_slots(9, 2, 1'b0, 1'b1, 767, 1);
        idle_in();
        chk(out_valid == 1'b1, "R7 valid after 768 valid slots", 64'(out_valid), 64'(1));
        drain(9, 0, 3072);

        // R6: in_sof restarts the count after a partial event
        write_slots(20, 1, 1'b0, 1'b1, 0, 200);
        write_slots(21, 0, 1'b1, 1'b1, 0, 767);
        idle_in();
        chk(out_valid == 1'b0, "R6 valid after restart + 767", 64'(out_valid), 64'(0));
        write_slots(21, 0, 1'b1, 1'b1, 767, 1);
        idle_in();
        chk(out_valid == 1'b1, "R6 valid after restart + 768", 64'(out_valid), 64'(1));
        drain(21, 1, 3072);

        // R8 / R10: ping-pong banks, busy, dropped slot, bank release
        write_slots(30, 0, 1'b0, 1'b1, 0, 768);
        idle_in();
        chk(out_valid == 1'b1 && busy == 1'b0, "R8 first event {valid,busy}", 64'({out_valid, busy}), 64'(2));
        write_slots(31, 2, 1'b1, 1'b1, 0, 767);
        idle_in();
        chk(busy == 1'b0, "R8 busy after second event 767 slots", 64'(busy), 64'(0));
        write_slots(31, 2, 1'b1, 1'b1, 767, 1);
        idle_in();
        chk(busy == 1'b1, "R8 busy with both banks full", 64'(busy), 64'(1));
        drive_junk(1'b0, 3'd0);
        idle_in();
        drain(30, 0, 3072);
        chk(busy == 1'b0, "R10 busy after last handshake", 64'(busy), 64'(0));
        chk(out_valid == 1'b1 && out_strip == 9'd0 && out_tb == 3'd0, "R10 next bank presented at strip 0",
            64'({out_valid, out_strip, out_tb}), 64'({1'b1, 9'd0, 3'd0}));
        write_slots(32, 3, 1'b0, 1'b0, 0, 767);
        idle_in();
        chk(busy == 1'b0, "R8 dropped slot not counted (767)", 64'(busy), 64'(0));
        write_slots(32, 3, 1'b0, 1'b0, 767, 1);
        idle_in();
        chk(busy == 1'b1, "R8 busy after third event 768", 64'(busy), 64'(1));
        drain(31, 3, 3072);
        chk(busy == 1'b0, "R10 busy released again", 64'(busy), 64'(0));
        drain(32, 0, 3072);
        chk(out_valid == 1'b0, "R10 all banks empty", 64'(out_valid), 64'(0));

        finish_up();
    end
endmodule